// File: doc/BRIEF.md
# Host Cycle Decoder for a Removable ATA Storage Card

This block sits between the host connector of a removable storage card and the card's internal register file. It watches the host address, the two active-low card enables, the space-select line and the four strobes. For each cycle it tells the register file which register or word is addressed, which address space is meant, which byte lanes take part, and whether the odd byte must be moved onto the low data lane. Host strobes are asynchronous to the card clock. They pass through two-flop synchronisers, and a small state machine turns each strobe into exactly one single-cycle read or write pulse.

The card comes up in one of two families of operation. In disk-drive mode only three address bits are decoded, into task-file and control registers. In card mode the memory strobes or, once the card is configured for I/O, the I/O strobes are used. Disk-drive mode is latched from the output-enable line while reset is held. Card mode routes odd bytes onto the low lane so that 8-bit hosts can reach every byte. Attribute space is even-only: its invalid lanes read as 0x00 and writes to them are dropped.

State machine: `IDLE` waits for a synchronised strobe. `RD_FIRE` lasts one cycle and emits the read pulse. `RD_HOLD` waits for the read strobe to drop. `WR_HOLD` waits for the write strobe to drop. `WR_FIRE` lasts one cycle and emits the write pulse. The transitions are: `IDLE`→`RD_FIRE` on a read strobe (read wins if both strobes are active); `IDLE`→`WR_HOLD` on a write strobe; `RD_FIRE`→`RD_HOLD` always; `RD_HOLD`→`IDLE` on read release; `WR_HOLD`→`WR_FIRE` on write release; `WR_FIRE`→`IDLE` always. The decode is re-captured every cycle in `IDLE` and `WR_HOLD` and is frozen in all other states.

Top module: `pcata_decode`

## Requirements
- R1: In card mode, with both enables low, the access is a word: `lane_en`=2'b11, `odd_to_low`=0, and `reg_idx` is the address with bit 0 cleared.
- R2: In card mode, with only `ce1_n` low, address bit 0 low gives `lane_en`=2'b01 and `odd_to_low`=0; address bit 0 high gives `lane_en`=2'b10 and `odd_to_low`=1.
- R3: In card mode, with only `ce2_n` low, the access is the odd byte on the upper lane: `lane_en`=2'b10, `odd_to_low`=0.
- R4: In memory mode with `reg_n` low, `space`=1 (attribute). An even byte access gives `lane_en`=2'b01. A word access gives `lane_en`=2'b01 with `zero_hi`=1. An odd byte access (only `ce1_n` low with address bit 0 high, or only `ce2_n` low) gives `lane_en`=2'b00 and `zero_lo`=1, and it produces no read or write pulse.
- R5: In disk-drive mode, with only `ce1_n` low, `space`=2 (task file) and `reg_idx` equals address bits 2:0, whatever the upper bits are. Offset 0 gives `lane_en`=2'b11 and `word16_n`=0. Other offsets give `lane_en`=2'b01 and `word16_n`=1.
- R6: In disk-drive mode, with only `ce2_n` low, offset 6 gives `space`=3 (control) and `lane_en`=2'b01. Any other offset gives `lane_en`=2'b00 and no pulse.
- R7: `ide_mode` equals the inverse of `oe_n` as sampled while `rst_n` is low, and it does not change after reset. In disk-drive mode `we_n` causes no pulse and `reg_n` does not change the decode.
- R8: Each qualifying read strobe yields exactly one single-cycle `rd_pulse`, issued while the strobe is still active.
- R9: Each qualifying write strobe yields exactly one single-cycle `wr_pulse`, issued only after the strobe has been released. `rd_pulse` and `wr_pulse` are never high together.
- R10: In I/O card mode (`io_mode`=1, not disk-drive), `iord_n`/`iowr_n` with `reg_n` low are task-file cycles (`space`=2) and use the lanes of R1–R3. `oe_n`/`we_n` produce no pulse. With `reg_n` high, `lane_en`=2'b00.
- R11: In card mode, `word16_n` is high except in I/O card mode at offset 0, where it is low.
- R12: After reset, `rd_pulse`=0, `wr_pulse`=0, `lane_en`=2'b00 and `word16_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Active-low reset; the mode is sampled while it is low |
| host_addr | input | ADDR_W | Host address bus |
| ce1_n | input | 1 | Even/low card enable, active low |
| ce2_n | input | 1 | Odd/high card enable, active low |
| reg_n | input | 1 | Low selects attribute space (memory) or the I/O cycle (I/O) |
| oe_n | input | 1 | Memory read strobe; low during reset selects disk-drive mode |
| we_n | input | 1 | Memory write strobe |
| iord_n | input | 1 | I/O read strobe |
| iowr_n | input | 1 | I/O write strobe |
| io_mode | input | 1 | Card has been configured for I/O operation |
| rd_pulse | output | 1 | One-cycle read request to the register file |
| wr_pulse | output | 1 | One-cycle write request to the register file |
| reg_idx | output | ADDR_W | Register or word index |
| space | output | 2 | 0 common, 1 attribute, 2 task file, 3 control |
| lane_en | output | 2 | Byte lane enables, bit 0 low lane |
| odd_to_low | output | 1 | Odd byte steered onto the low lane |
| zero_lo | output | 1 | Drive 0x00 on the low lane for this read |
| zero_hi | output | 1 | Drive 0x00 on the high lane for this read |
| word16_n | output | 1 | Low when the addressed location expects a word transfer |
| ide_mode | output | 1 | Latched disk-drive mode |

## Verification
The read and write synchronisers can both report an active strobe in the same cycle. The bench provokes this by asserting a read and a write strobe together in memory mode. It judges the result by counting exactly one read pulse and no write pulse, and an assertion forbids the two pulses from ever being high together. The decode capture can also coincide with a strobe release. The bench checks this by confirming that the lane enables seen at the write pulse match the ones decoded while the strobe was held.

// File: rtl/pcata_pkg.sv
package pcata_pkg;
    typedef enum logic [1:0] {
        SP_COMMON = 2'd0,
        SP_ATTR   = 2'd1,
        SP_TASK   = 2'd2,
        SP_CTRL   = 2'd3
    } space_e;

    typedef enum logic [2:0] {
        IDLE    = 3'd0,
        RD_FIRE = 3'd1,
        RD_HOLD = 3'd2,
        WR_HOLD = 3'd3,
        WR_FIRE = 3'd4
    } cyc_state_e;

    typedef struct packed {
        space_e     space;
        logic [1:0] lane_en;
        logic       odd_to_low;
        logic       zero_lo;
        logic       zero_hi;
        logic       word16;
    } lane_dec_t;
endpackage

// File: rtl/pcata_sync.sv
module pcata_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pcata_lane_decode.sv
module pcata_lane_decode
    import pcata_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int TF_BITS = 3,
    parameter int CTRL_OFS = 6
) (
    input  logic              ide,
    input  logic              io_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              reg_n,
    output lane_dec_t         dec,
    output logic [ADDR_W-1:0] idx
);
    logic lo_sel, hi_sel, both, odd_byte, tf_zero;
    logic [1:0] card_lanes;

    assign lo_sel   = !ce1_n;
    assign hi_sel   = !ce2_n;
    assign both     = lo_sel && hi_sel;
    assign odd_byte = (lo_sel && !hi_sel && addr[0]) || (hi_sel && !lo_sel);
    assign tf_zero  = (addr[TF_BITS-1:0] == '0);

    always_comb begin
        if (both)        card_lanes = 2'b11;
        else if (hi_sel) card_lanes = 2'b10;
        else if (lo_sel) card_lanes = addr[0] ? 2'b10 : 2'b01;
        else             card_lanes = 2'b00;
    end

    always_comb begin
        dec = '0;
        idx = '0;
        if (ide) begin
            idx[TF_BITS-1:0] = addr[TF_BITS-1:0];
            if (lo_sel && !hi_sel) begin
                dec.space   = SP_TASK;
                dec.lane_en = tf_zero ? 2'b11 : 2'b01;
                dec.word16  = tf_zero;
            end else if (hi_sel && !lo_sel) begin
                dec.space   = SP_CTRL;
                dec.lane_en = (addr[TF_BITS-1:0] == TF_BITS'(CTRL_OFS)) ? 2'b01 : 2'b00;
            end
        end else begin
            idx        = {addr[ADDR_W-1:1], 1'b0};
            dec.space  = SP_COMMON;
            dec.lane_en    = card_lanes;
            dec.odd_to_low = lo_sel && !hi_sel && addr[0];
            if (io_mode) begin
                dec.space  = SP_TASK;
                dec.word16 = tf_zero && (lo_sel || hi_sel);
                if (reg_n) begin
                    dec.lane_en    = 2'b00;
                    dec.odd_to_low = 1'b0;
                end
            end else if (!reg_n && (lo_sel || hi_sel)) begin
                dec.space      = SP_ATTR;
                dec.odd_to_low = 1'b0;
                if (odd_byte) begin
                    dec.lane_en = 2'b00;
                    dec.zero_lo = 1'b1;
                end else begin
                    dec.lane_en = 2'b01;
                    dec.zero_hi = both;
                end
            end
        end
    end
endmodule

// File: rtl/pcata_cycle_fsm.sv
module pcata_cycle_fsm
    import pcata_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_s,
    input  logic wr_s,
    input  logic lanes_live,
    output logic cap_en,
    output logic rd_pulse,
    output logic wr_pulse
);
    cyc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE:    if (rd_s) state_d = RD_FIRE;
                     else if (wr_s) state_d = WR_HOLD;
            RD_FIRE: state_d = RD_HOLD;
            RD_HOLD: if (!rd_s) state_d = IDLE;
            WR_HOLD: if (!wr_s) state_d = WR_FIRE;
            WR_FIRE: state_d = IDLE;
            default: state_d = IDLE;
        endcase
    end

    always_comb begin
        cap_en   = 1'b0;
        rd_pulse = 1'b0;
        wr_pulse = 1'b0;
        unique case (state_q)
            IDLE:    cap_en   = 1'b1;
            RD_FIRE: rd_pulse = lanes_live;
            RD_HOLD: ;
            WR_HOLD: cap_en   = 1'b1;
            WR_FIRE: wr_pulse = lanes_live;
            default: ;
        endcase
    end
endmodule

// File: rtl/pcata_decode.sv
module pcata_decode
    import pcata_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int SYNC_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              ce1_n,
    input  logic              ce2_n,
    input  logic              reg_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              iord_n,
    input  logic              iowr_n,
    input  logic              io_mode,
    output logic              rd_pulse,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] reg_idx,
    output logic [1:0]        space,
    output logic [1:0]        lane_en,
    output logic              odd_to_low,
    output logic              zero_lo,
    output logic              zero_hi,
    output logic              word16_n,
    output logic              ide_mode
);
    logic              ide_q;
    logic              use_io, card_sel;
    logic [1:0]        raw_req, sync_req;
    lane_dec_t         dec_c, dec_q;
    logic [ADDR_W-1:0] idx_c, idx_q;
    logic              cap_en;

    // Mode strap: sampled every clock while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) ide_q <= !oe_n;
    end

    assign use_io   = ide_q || io_mode;
    assign card_sel = !ce1_n || !ce2_n;
    assign raw_req[0] = card_sel && (use_io ? !iord_n : !oe_n);
    assign raw_req[1] = card_sel && (use_io ? !iowr_n : !we_n);

    pcata_sync #(.WIDTH(2), .STAGES(SYNC_LEN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_req),
        .sync_out (sync_req)
    );

    pcata_lane_decode #(.ADDR_W(ADDR_W)) u_dec (
        .ide     (ide_q),
        .io_mode (io_mode),
        .addr    (host_addr),
        .ce1_n   (ce1_n),
        .ce2_n   (ce2_n),
        .reg_n   (reg_n),
        .dec     (dec_c),
        .idx     (idx_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
            idx_q <= '0;
        end else if (cap_en) begin
            dec_q <= dec_c;
            idx_q <= idx_c;
        end
    end

    pcata_cycle_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_s       (sync_req[0]),
        .wr_s       (sync_req[1]),
        .lanes_live (|dec_q.lane_en),
        .cap_en     (cap_en),
        .rd_pulse   (rd_pulse),
        .wr_pulse   (wr_pulse)
    );

    assign reg_idx    = idx_q;
    assign space      = dec_q.space;
    assign lane_en    = dec_q.lane_en;
    assign odd_to_low = dec_q.odd_to_low;
    assign zero_lo    = dec_q.zero_lo;
    assign zero_hi    = dec_q.zero_hi;
    assign word16_n   = !dec_q.word16;
    assign ide_mode   = ide_q;
endmodule

// File: rtl/pcata_decode_chk.sv
module pcata_decode_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_pulse,
    input logic       wr_pulse,
    input logic [1:0] space,
    input logic [1:0] lane_en,
    input logic       zero_lo,
    input logic       ide_mode
);
    // R8
    rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);

    // R9
    wr_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    // R9
    no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_pulse && wr_pulse));

    // R4
    void_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse || wr_pulse) |-> (lane_en != 2'b00));

    // R4
    zero_void_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_lo |-> (lane_en == 2'b00 && space == 2'd1));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(ide_mode));

    // R5
    ide_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ide_mode && lane_en != 2'b00) |-> space[1]);
endmodule

bind pcata_decode pcata_decode_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_pulse (rd_pulse),
    .wr_pulse (wr_pulse),
    .space    (space),
    .lane_en  (lane_en),
    .zero_lo  (zero_lo),
    .ide_mode (ide_mode)
);

// File: tb/sim_pcata_decode.sv
`timescale 1ns/100ps
module sim_pcata_decode;
    localparam int AW = 11;
    logic clk = 0, rst_n = 0;
    logic [AW-1:0] host_addr = '0;
    logic ce1_n = 1, ce2_n = 1, reg_n = 1, oe_n = 1, we_n = 1, iord_n = 1, iowr_n = 1, io_mode = 0;
    logic rd_pulse, wr_pulse, odd_to_low, zero_lo, zero_hi, word16_n, ide_mode;
    logic [AW-1:0] reg_idx;
    logic [1:0] space, lane_en;

    int checks = 0, fails = 0;
    int n_rd, n_wr;
    bit strobe_held, wr_early;
    logic [1:0] s_lane, s_space, w_lane;
    logic s_swap, s_zlo, s_zhi, s_w16;
    logic [AW-1:0] s_idx;

    always #2.5 clk = ~clk;

    pcata_decode u0 (.*);

    always @(negedge clk) begin
        if (rd_pulse) n_rd++;
        if (wr_pulse) begin
            n_wr++;
            w_lane = lane_en;
            if (strobe_held) wr_early = 1;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic oe_level);
        rst_n = 0; oe_n = oe_level;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        oe_n = 1;
    endtask

    // kind: 0 OE, 1 WE, 2 IORD, 3 IOWR, 4 OE+WE together
    task automatic cycle(int kind, logic [AW-1:0] a, logic c1, logic c2, logic rg);
        n_rd = 0; n_wr = 0; wr_early = 0;
        @(negedge clk);
        host_addr = a; ce1_n = c1; ce2_n = c2; reg_n = rg;
        repeat (3) @(negedge clk);
        strobe_held = 1;
        case (kind)
            0: oe_n = 0;
            1: we_n = 0;
            2: iord_n = 0;
            3: iowr_n = 0;
            default: begin oe_n = 0; we_n = 0; end
        endcase
        repeat (6) @(negedge clk);
        s_lane = lane_en; s_space = space; s_swap = odd_to_low; s_zlo = zero_lo;
        s_zhi = zero_hi; s_w16 = word16_n; s_idx = reg_idx;
        oe_n = 1; we_n = 1; iord_n = 1; iowr_n = 1;
        strobe_held = 0;
        repeat (8) @(negedge clk);
        ce1_n = 1; ce2_n = 1; reg_n = 1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        do_reset(1'b1);
        check("R12 rd_pulse", rd_pulse, 0);
        check("R12 wr_pulse", wr_pulse, 0);
        check("R12 lane_en", lane_en, 0);
        check("R12 word16_n", word16_n, 1);
        check("R7 ide_mode off", ide_mode, 0);
    endtask

    task automatic t_common;
        cycle(0, 11'h2A5, 0, 0, 1);
        check("R1 lanes", s_lane, 2'b11); check("R1 swap", s_swap, 0);
        check("R1 idx", s_idx, 11'h2A4); check("R8 one read", n_rd, 1);
        check("R11 word16_n mem", s_w16, 1);
        cycle(0, 11'h010, 0, 1, 1);
        check("R2 even lanes", s_lane, 2'b01); check("R2 even swap", s_swap, 0);
        cycle(1, 11'h011, 0, 1, 1);
        check("R2 odd lanes", s_lane, 2'b10); check("R2 odd swap", s_swap, 1);
        check("R9 one write", n_wr, 1); check("R9 after release", wr_early, 0);
        check("R9 lanes at pulse", w_lane, 2'b10);
        cycle(0, 11'h020, 1, 0, 1);
        check("R3 lanes", s_lane, 2'b10); check("R3 swap", s_swap, 0);
        check("R3 space", s_space, 0);
    endtask

    task automatic t_attr;
        cycle(0, 11'h008, 0, 1, 0);
        check("R4 even space", s_space, 1); check("R4 even lanes", s_lane, 2'b01);
        cycle(0, 11'h008, 0, 0, 0);
        check("R4 word lanes", s_lane, 2'b01); check("R4 word zero_hi", s_zhi, 1);
        cycle(0, 11'h009, 0, 1, 0);
        check("R4 odd lanes", s_lane, 2'b00); check("R4 odd zero_lo", s_zlo, 1);
        check("R4 odd no read", n_rd, 0);
        cycle(1, 11'h00A, 1, 0, 0);
        check("R4 hi-only no write", n_wr, 0); check("R4 hi-only zero_lo", s_zlo, 1);
    endtask

    task automatic t_dual;
        cycle(4, 11'h040, 0, 0, 1);
        check("R9 dual read wins", n_rd, 1);
        check("R9 dual no write", n_wr, 0);
    endtask

    task automatic t_io;
        io_mode = 1;
        cycle(2, 11'h3F8, 0, 0, 0);
        check("R10 space", s_space, 2); check("R10 lanes", s_lane, 2'b11);
        check("R11 word16_n ofs0", s_w16, 0); check("R10 read", n_rd, 1);
        cycle(3, 11'h3F3, 0, 1, 0);
        check("R10 odd lanes", s_lane, 2'b10); check("R11 word16_n ofs3", s_w16, 1);
        check("R10 write", n_wr, 1);
        cycle(0, 11'h3F8, 0, 0, 0);
        check("R10 OE ignored", n_rd, 0);
        cycle(2, 11'h3F8, 0, 0, 1);
        check("R10 reg high lanes", s_lane, 2'b00); check("R10 reg high no read", n_rd, 0);
        io_mode = 0;
    endtask

    task automatic t_ide;
        do_reset(1'b0);
        check("R7 ide latched", ide_mode, 1);
        repeat (5) @(negedge clk);
        check("R7 ide held", ide_mode, 1);
        cycle(2, 11'h7F8, 0, 1, 1);
        check("R5 space", s_space, 2); check("R5 idx", s_idx, 0);
        check("R5 data lanes", s_lane, 2'b11); check("R5 word16_n", s_w16, 0);
        cycle(2, 11'h405, 0, 1, 0);
        check("R5 idx upper ignored", s_idx, 5); check("R5 byte lanes", s_lane, 2'b01);
        check("R5 byte word16_n", s_w16, 1); check("R7 reg ignored space", s_space, 2);
        cycle(3, 11'h006, 1, 0, 1);
        check("R6 ctrl space", s_space, 3); check("R6 ctrl lanes", s_lane, 2'b01);
        check("R6 ctrl write", n_wr, 1);
        cycle(2, 11'h005, 1, 0, 1);
        check("R6 other lanes", s_lane, 2'b00); check("R6 other no read", n_rd, 0);
        cycle(1, 11'h001, 0, 1, 1);
        check("R7 WE ignored", n_wr, 0);
    endtask

    initial begin
        fork
            begin
                t_reset(); t_common(); t_attr(); t_dual(); t_io(); t_ide();
            end
            begin
                repeat (20000) @(negedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule